// File: doc/BRIEF.md
# Write-only serial configuration receiver

This block is a receive-only slave on a two-wire serial bus. The bus has a clock line and a data line that any device may pull low. The block fills a bank of eight 8-bit configuration registers. A faster system clock samples both bus lines through a synchronizer. The block detects start and stop conditions on the sampled lines and shifts in bytes most significant bit first.

A write frame opens with an address byte. Two framing bytes follow (a command byte and a count byte), which are acknowledged but not used. Up to eight data bytes come last, and they land in registers 0 to 7 in the order they arrive. The block only drives the data line low, and only during acknowledge slots. It never returns read data.

Every register has a defined reset value, so the device works if no write ever happens. A one-cycle update pulse tells the logic downstream that a frame which changed the registers has ended.

Top module: `cfg_serial_rx`

## Requirements
- R1: A synchronous active-low reset puts register N at 8'h11*(N+1), so 8'h11 for register 0 up to 8'h88 for register 7. Register N sits on bits 8N+7..8N of `cfg_regs_o`. The same reset holds `sda_pull_o` and `cfg_upd_o` at 0.
- R2: The only address byte the block answers is 8'hD2, which has the write direction in bit 0. For that address, `sda_pull_o` is 1 while SCL is high on the ninth clock. For any other address byte, the block does not acknowledge that byte or any later byte of the frame, and no register changes.
- R3: In an accepted frame, the block acknowledges the second byte (command) and the third byte (count). Their values never reach a register.
- R4: In an accepted frame, the fourth byte onward are data bytes 0 to 7. Data byte N, received most significant bit first, is written to register N and acknowledged. A frame that carries only K data bytes changes only registers 0 to K-1.
- R5: Bytes after data byte 7 are neither acknowledged nor stored.
- R6: `cfg_upd_o` is high for exactly one system cycle after a stop condition that ends a frame in which at least one data byte was stored. Any other stop leaves it low.
- R7: A start or stop condition in the middle of a byte drops the partly received byte. Data bytes completed before that point stay stored. A repeated start begins a new frame, which is checked against the address again.
- R8: The block pulls SDA low only in acknowledge slots. It releases SDA on the falling SCL edge that ends the acknowledge clock, or at a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line as seen at the pin |
| sda_i | input | 1 | Serial bus data line as seen at the pin, the wired result |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| cfg_regs_o | output | 64 | Eight configuration registers, register N on bits 8N+7..8N |
| cfg_upd_o | output | 1 | One-cycle pulse after a frame that stored data ends |

## Verification
A start condition in the middle of a byte both drops that byte and re-arms the frame with a fresh address compare, on the same detected edge. The bench provokes this with a repeated start after five bits of a data byte, then sends a one-byte write. It judges the result by three things: the register the lost byte was aimed at keeps its value, register 0 takes the new frame's byte, and exactly one update pulse follows. A second case stops a frame in the middle of a byte after one full data byte. Here the completed byte must stay committed and must still raise the update pulse.

// File: rtl/cfg_serial_pkg.sv
// Package: shared types for the serial configuration receiver.
// Assumes nothing beyond a standard 1800-2017 compiler.
package cfg_serial_pkg;

    // Frame receiver state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // bus free or no frame yet
        ST_SHIFT = 2'd1,   // shifting in data bits
        ST_ACK   = 2'd2,   // holding SDA low for the acknowledge clock
        ST_SKIP  = 2'd3    // frame not for us, wait for start or stop
    } rx_state_e;

    // Default write address, write direction bit included
    localparam logic [7:0] DEFAULT_DEV_ADDR = 8'hD2;

endpackage

// File: rtl/cfg_line_sync.sv
// Module: cfg_line_sync
// Brings one asynchronous bus line into the system clock domain through
// STAGES flops, then keeps one history flop for edge detection.
// Assumes the line idles high (open-drain bus), so reset loads ones.
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] chain_q;

    // Synchronizer chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], line_i};
        end
    end

    // Level is the last synchronized stage; edges compare it with history
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/cfg_frame_fsm.sv
// Module: cfg_frame_fsm
// Receives bytes from synchronized bus events, checks the address, skips
// the framing bytes, issues register writes and drives the acknowledge.
// Assumes start/stop and SCL edges are single-cycle pulses that never
// coincide with each other.
module cfg_frame_fsm
    import cfg_serial_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         NUM_REGS   = 8,
    parameter int         SKIP_BYTES = 2,
    parameter logic [7:0] DEV_ADDR   = DEFAULT_DEV_ADDR,
    localparam int        REG_IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise_i,
    input  logic                 scl_fall_i,
    input  logic                 sda_lvl_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    output logic                 wr_en_o,
    output logic [REG_IDX_W-1:0] wr_idx_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic                 sda_pull_o,
    output logic                 upd_o
);

    localparam int FIRST_DATA = 1 + SKIP_BYTES;
    localparam int END_BYTE   = FIRST_DATA + NUM_REGS;
    localparam int BYTE_W     = $clog2(END_BYTE + 1);
    localparam int BIT_W      = $clog2(DATA_W + 1);

    rx_state_e             state_q;
    logic [DATA_W-1:0]     shreg_q;
    logic [BIT_W-1:0]      bit_cnt_q;
    logic [BYTE_W-1:0]     byte_idx_q;
    logic [REG_IDX_W-1:0]  data_idx_q;
    logic                  pull_q;
    logic                  wrote_q;
    logic                  upd_q;

    logic byte_done;
    logic is_addr;
    logic addr_ok;
    logic data_slot;
    logic accept;

    // Decode the end of a byte and what to do with it
    always_comb begin
        byte_done = (state_q == ST_SHIFT) && scl_fall_i
                    && (bit_cnt_q == BIT_W'(DATA_W));
        is_addr   = (byte_idx_q == '0);
        addr_ok   = (shreg_q[DATA_W-1 -: 8] == DEV_ADDR);
        data_slot = (byte_idx_q >= BYTE_W'(FIRST_DATA))
                    && (byte_idx_q < BYTE_W'(END_BYTE));
        accept    = is_addr ? addr_ok : (byte_idx_q < BYTE_W'(END_BYTE));
    end

    // Frame sequencing: bit/byte counters, shifter, ack drive, write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            data_idx_q <= '0;
            pull_q     <= 1'b0;
            wrote_q    <= 1'b0;
        end else if (start_i) begin
            state_q    <= ST_SHIFT;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            data_idx_q <= '0;
            pull_q     <= 1'b0;
            wrote_q    <= 1'b0;
        end else if (stop_i) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            pull_q     <= 1'b0;
            wrote_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_SHIFT: begin
                    if (scl_rise_i && (bit_cnt_q < BIT_W'(DATA_W))) begin
                        shreg_q   <= {shreg_q[DATA_W-2:0], sda_lvl_i};
                        bit_cnt_q <= bit_cnt_q + BIT_W'(1);
                    end else if (byte_done) begin
                        if (accept) begin
                            pull_q  <= 1'b1;
                            state_q <= ST_ACK;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                        if (data_slot) begin
                            wrote_q    <= 1'b1;
                            data_idx_q <= data_idx_q + REG_IDX_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        pull_q     <= 1'b0;
                        state_q    <= ST_SHIFT;
                        bit_cnt_q  <= '0;
                        byte_idx_q <= byte_idx_q + BYTE_W'(1);
                    end
                end
                default: begin
                    // idle or skipping: wait for the next start or stop
                end
            endcase
        end
    end

    // Update pulse: one cycle after a stop that closes a storing frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= stop_i && wrote_q;
        end
    end

    // Drive the write port straight from the completed byte
    always_comb begin
        wr_en_o    = byte_done && data_slot;
        wr_idx_o   = data_idx_q;
        wr_data_o  = shreg_q;
        sda_pull_o = pull_q;
        upd_o      = upd_q;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Holds NUM_REGS configuration registers, each with its own reset value
// taken from RESET_VALS. Accepts one write per cycle.
// Assumes wr_idx_i is below NUM_REGS whenever wr_en_i is high.
module cfg_reg_bank #(
    parameter int                          NUM_REGS   = 8,
    parameter int                          DATA_W     = 8,
    parameter logic [NUM_REGS*DATA_W-1:0]  RESET_VALS = '0,
    localparam int                         REG_IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [REG_IDX_W-1:0]        wr_idx_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [NUM_REGS*DATA_W-1:0]  regs_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;

        // One register: reset to its default, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= RESET_VALS[g*DATA_W +: DATA_W];
            end else if (wr_en_i && (wr_idx_i == REG_IDX_W'(g))) begin
                val_q <= wr_data_i;
            end
        end

        assign regs_o[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/cfg_serial_rx.sv
// Module: cfg_serial_rx (top)
// Write-only two-wire configuration receiver. It synchronizes SCL and SDA,
// detects start and stop, receives frames and loads the register bank.
// Assumes the system clock is several times faster than SCL, so each bus
// phase lasts at least a few system cycles.
module cfg_serial_rx
    import cfg_serial_pkg::*;
#(
    parameter int                          NUM_REGS     = 8,
    parameter int                          DATA_W       = 8,
    parameter int                          SKIP_BYTES   = 2,
    parameter int                          SYNC_STAGES  = 2,
    parameter logic [7:0]                  DEV_ADDR     = DEFAULT_DEV_ADDR,
    parameter logic [NUM_REGS*DATA_W-1:0]  REG_DEFAULTS = 64'h8877_6655_4433_2211
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_pull_o,
    output logic [NUM_REGS*DATA_W-1:0]  cfg_regs_o,
    output logic                        cfg_upd_o
);

    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int N_LINES   = 2;   // index 0 = SCL, index 1 = SDA

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] line_lvl;
    logic [N_LINES-1:0] line_rise;
    logic [N_LINES-1:0] line_fall;

    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_det;
    logic                 stop_det;
    logic                 wr_en;
    logic [REG_IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0]    wr_data;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < N_LINES; l++) begin : g_sync
        cfg_line_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[l]),
            .level_o (line_lvl[l]),
            .rise_o  (line_rise[l]),
            .fall_o  (line_fall[l])
        );
    end

    // Bus conditions: SDA moving while SCL is high marks start or stop
    always_comb begin
        scl_rise  = line_rise[0];
        scl_fall  = line_fall[0];
        start_det = line_fall[1] && line_lvl[0];
        stop_det  = line_rise[1] && line_lvl[0];
    end

    cfg_frame_fsm #(
        .DATA_W     (DATA_W),
        .NUM_REGS   (NUM_REGS),
        .SKIP_BYTES (SKIP_BYTES),
        .DEV_ADDR   (DEV_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_lvl_i  (line_lvl[1]),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .sda_pull_o (sda_pull_o),
        .upd_o      (cfg_upd_o)
    );

    cfg_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .DATA_W     (DATA_W),
        .RESET_VALS (REG_DEFAULTS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (cfg_regs_o)
    );

endmodule

// File: rtl/cfg_serial_rx_chk.sv
// Module: cfg_serial_rx_chk
// Checks the timing relations between bus events, the acknowledge drive,
// register writes and the update pulse. It is bound to cfg_serial_rx.
module cfg_serial_rx_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sda_pull_o,
    input logic [NUM_REGS*DATA_W-1:0]  cfg_regs_o,
    input logic                        cfg_upd_o,
    input logic                        scl_fall,
    input logic                        start_det,
    input logic                        stop_det,
    input logic                        wr_en
);

    AST_ACK_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall)); // R2

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> $past(scl_fall || start_det || stop_det)); // R8

    AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> scl_fall); // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs_o)); // R2

    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd_o |=> !cfg_upd_o); // R6

    AST_UPD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd_o |-> $past(stop_det)); // R6

endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .cfg_regs_o (cfg_regs_o),
    .cfg_upd_o  (cfg_upd_o),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .wr_en      (wr_en)
);

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;

    localparam int Q = 8;                    // system cycles per bus quarter
    localparam logic [7:0] ADDR = 8'hD2;
    // vector: {address[19:12], data byte count[11:8], seed[7:0]}
    localparam int NVEC = 6;
    localparam logic [19:0] VEC [NVEC] = '{
        {8'hD2, 4'd8, 8'h40},
        {8'hD3, 4'd8, 8'h90},
        {8'hD2, 4'd3, 8'h07},
        {8'h52, 4'd2, 8'hAB},
        {8'hD2, 4'd0, 8'h66},
        {8'hD2, 4'd8, 8'hF0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_pull_o;
    logic [63:0] cfg_regs_o;
    logic        cfg_upd_o;

    int n_tests = 0;
    int n_fail  = 0;
    int upd_cnt = 0;
    logic [7:0] model [8];

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_pull_o;

    cfg_serial_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull_o),
        .cfg_regs_o (cfg_regs_o),
        .cfg_upd_o  (cfg_upd_o)
    );

    always @(posedge clk) if (cfg_upd_o) upd_cnt <= upd_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int k);
        return 8'(8'h11 * (k + 1));
    endfunction

    function automatic logic [7:0] data_of(input logic [7:0] seed, input int k);
        return seed + 8'(k * 29);
    endfunction

    task automatic check_regs(input string req);
        for (int k = 0; k < 8; k++)
            check(cfg_regs_o[k*8 +: 8] == model[k], req, $sformatf("reg%0d", k),
                  32'(cfg_regs_o[k*8 +: 8]), 32'(model[k]));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            if (i == 0)
                check(sda_pull_o == 1'b0, "R8", "pull during data bit", 32'(sda_pull_o), 0);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_pull_o;
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(4);
        rst_n = 1'b1; tick(2);
        for (int k = 0; k < 8; k++) model[k] = dflt(k);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic ack;
        int   u0;
        do_reset();
        // R1: reset state
        check_regs("R1");
        check(sda_pull_o == 1'b0, "R1", "pull after reset", 32'(sda_pull_o), 0);
        check(cfg_upd_o == 1'b0, "R1", "update after reset", 32'(cfg_upd_o), 0);

        // table walk: R2 R3 R4 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] a;
            int         n;
            logic [7:0] seed;
            bit         hit;
            a = VEC[v][19:12]; n = int'(VEC[v][11:8]); seed = VEC[v][7:0];
            hit = (a == ADDR);
            u0 = upd_cnt;
            bus_start();
            send_byte(a, ack);
            check(ack == hit, "R2", $sformatf("vec%0d address ack", v), 32'(ack), 32'(hit));
            send_byte(~seed, ack);
            check(ack == hit, "R3", "command byte ack", 32'(ack), 32'(hit));
            send_byte(seed ^ 8'h5A, ack);
            check(ack == hit, "R3", "count byte ack", 32'(ack), 32'(hit));
            for (int k = 0; k < n; k++) begin
                send_byte(data_of(seed, k), ack);
                check(ack == hit, "R4", $sformatf("data%0d ack", k), 32'(ack), 32'(hit));
                if (hit) model[k] = data_of(seed, k);
            end
            bus_stop();
            tick(8);
            check_regs(hit ? "R4" : "R2");
            check((upd_cnt - u0) == ((hit && n > 0) ? 1 : 0), "R6", "update pulses",
                  32'(upd_cnt - u0), 32'((hit && n > 0) ? 1 : 0));
        end

        // R5: ninth data byte neither acknowledged nor stored
        u0 = upd_cnt;
        bus_start();
        send_byte(ADDR, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        for (int k = 0; k < 8; k++) begin
            send_byte(data_of(8'h33, k), ack);
            model[k] = data_of(8'h33, k);
        end
        send_byte(8'hEE, ack);
        check(ack == 1'b0, "R5", "ack past last register", 32'(ack), 0);
        bus_stop(); tick(8);
        check_regs("R5");
        check((upd_cnt - u0) == 1, "R6", "update after full frame", 32'(upd_cnt - u0), 1);

        // R7: stop in mid byte keeps the completed byte and still updates
        u0 = upd_cnt;
        bus_start();
        send_byte(ADDR, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        send_byte(8'hA7, ack);
        model[0] = 8'hA7;
        send_bits(8'hFF, 4);
        bus_stop(); tick(8);
        check_regs("R7");
        check((upd_cnt - u0) == 1, "R7", "update after stop abort", 32'(upd_cnt - u0), 1);

        // R7: repeated start in mid byte drops it and opens a fresh frame
        u0 = upd_cnt;
        bus_start();
        send_byte(ADDR, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'hC1, ack);
        send_bits(8'hFF, 5);
        bus_start();
        send_byte(ADDR, ack);
        check(ack == 1'b1, "R7", "address ack after restart", 32'(ack), 1);
        send_byte(8'h9C, ack);
        send_byte(8'h01, ack);
        send_byte(8'h5E, ack);
        model[0] = 8'h5E;
        bus_stop(); tick(8);
        check_regs("R7");
        check((upd_cnt - u0) == 1, "R7", "update after restart frame", 32'(upd_cnt - u0), 1);

        // R1: reset again restores the defaults
        do_reset();
        check_regs("R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule